// File: doc/BRIEF.md
# Configurable Output Logic Macrocell

This block is a single output cell of a sum-of-products logic device. It receives the OR-sum of its product terms, a dedicated output-enable term, the device-wide asynchronous reset and synchronous set terms, and a two-bit mode code. From these it drives a tri-state pin model (value plus enable) and a feedback line that returns to the AND array.

The mode code picks three things together: whether the pin is driven from a D flip-flop or straight from the sum, whether the pin level is inverted, and whether feedback is taken from the register or from the pin. Inversion sits after the register, so the pin level seen after a set or reset depends on the polarity chosen. A test preload path can force the register to any value on a clock edge.

Top module: `olm_cell`

## Requirements
- R1: While `rst_ni` is low the register holds 0; in mode 00 the pin reads 1 and the feedback reads 0.
- R2: With no reset, preload or set active, the register takes `sum_i` on each rising clock edge.
- R3: When `ar_i` is 1 the register becomes 0 at once, without a clock edge.
- R4: When `ss_i` is 1 the register becomes 1 on the next rising clock edge.
- R5: Inversion follows the register: after a set, mode 00 drives 0 on the pin and mode 01 drives 1.
- R6: Mode code bit 1 selects combinational (1) or registered (0) operation; bit 0 selects active-high (1) or active-low (0); the register keeps clocking in combinational modes.
- R7: In modes 10 and 11 the pin follows `sum_i` in the same cycle, inverted for 10 and true for 11.
- R8: `pin_oe_o` follows `oe_term_i`; disabling the output does not alter the register.
- R9: In modes 10 and 11 the feedback is the pin level: `pin_o` while enabled, `pin_i` while disabled.
- R10: In modes 00 and 01 the feedback is the true register value for either polarity and `pin_i` has no effect.
- R11: With `pl_en_i` at 1 the register takes `pl_val_i` on the next rising edge.
- R12: Priority is `ar_i` over preload over `ss_i` over `sum_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low power-on reset |
| sum_i | input | 1 | OR-sum of the cell's product terms |
| oe_term_i | input | 1 | Output-enable product term |
| ar_i | input | 1 | Asynchronous reset term |
| ss_i | input | 1 | Synchronous set term |
| mode_i | input | 2 | Mode code (bit 1 combinational, bit 0 active-high) |
| pl_en_i | input | 1 | Test preload enable |
| pl_val_i | input | 1 | Test preload value |
| pin_i | input | 1 | Level driven onto the pin from outside |
| pin_o | output | 1 | Value driven to the pin |
| pin_oe_o | output | 1 | Pin driver enable |
| fb_o | output | 1 | Feedback to the array |

## Verification
The hardest state to reach is the register's content while the cell runs in a combinational mode, since neither pin nor feedback shows it there. The stimulus clocks data, preload or set in modes 10/11 and then switches the mode code to a registered mode before the next edge, so the stored value appears on the pin without being overwritten. Reset between edges is reached by raising `ar_i` mid-cycle and sampling before any clock edge.

// File: rtl/olm_pkg.sv
package olm_pkg;
  typedef enum logic [1:0] {
    MODE_REG_LOW   = 2'b00,
    MODE_REG_HIGH  = 2'b01,
    MODE_COMB_LOW  = 2'b10,
    MODE_COMB_HIGH = 2'b11
  } olm_mode_e;

  localparam int unsigned MODE_W = 2;

  function automatic logic mode_is_comb(input logic [MODE_W-1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_is_high(input logic [MODE_W-1:0] m);
    return m[0];
  endfunction
endpackage

// File: rtl/olm_reg.sv
module olm_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ar_i,
  input  logic ss_i,
  input  logic pl_en_i,
  input  logic pl_val_i,
  input  logic d_i,
  output logic q_o
);
  logic q_q;

  // async clear beats preload, preload beats set, set beats data
  always_ff @(posedge clk_i or negedge rst_ni or posedge ar_i) begin
    if (!rst_ni || ar_i)  q_q <= 1'b0;
    else if (pl_en_i)     q_q <= pl_val_i;
    else if (ss_i)        q_q <= 1'b1;
    else                  q_q <= d_i;
  end

  assign q_o = q_q;

  assert_ar_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_i |-> !q_o);
  assert_set_loads_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_i && !pl_en_i && !ar_i) |=> (q_o || ar_i));
  assert_preload_loads_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pl_en_i && !ar_i) |=> ((q_o == $past(pl_val_i)) || ar_i));
  assert_data_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pl_en_i && !ss_i && !ar_i) |=> ((q_o == $past(d_i)) || ar_i));
endmodule

// File: rtl/olm_outsel.sv
module olm_outsel
  import olm_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              q_i,
  input  logic              sum_i,
  input  logic              oe_term_i,
  output logic              pin_o,
  output logic              pin_oe_o
);
  logic src;

  always_comb begin
    src      = mode_is_comb(mode_i) ? sum_i : q_i;
    pin_o    = mode_is_high(mode_i) ? src : ~src;
    pin_oe_o = oe_term_i;
  end
endmodule

// File: rtl/olm_fbsel.sv
module olm_fbsel
  import olm_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              q_i,
  input  logic              drv_i,
  input  logic              drv_oe_i,
  input  logic              pin_i,
  output logic              fb_o
);
  logic pin_level;

  always_comb begin
    pin_level = drv_oe_i ? drv_i : pin_i;
    fb_o      = mode_is_comb(mode_i) ? pin_level : q_i;
  end
endmodule

// File: rtl/olm_cell.sv
module olm_cell
  import olm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sum_i,
  input  logic              oe_term_i,
  input  logic              ar_i,
  input  logic              ss_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pl_en_i,
  input  logic              pl_val_i,
  input  logic              pin_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              fb_o
);
  logic q;

  olm_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ar_i     (ar_i),
    .ss_i     (ss_i),
    .pl_en_i  (pl_en_i),
    .pl_val_i (pl_val_i),
    .d_i      (sum_i),
    .q_o      (q)
  );

  olm_outsel u_outsel (
    .mode_i    (mode_i),
    .q_i       (q),
    .sum_i     (sum_i),
    .oe_term_i (oe_term_i),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o)
  );

  olm_fbsel u_fbsel (
    .mode_i   (mode_i),
    .q_i      (q),
    .drv_i    (pin_o),
    .drv_oe_i (pin_oe_o),
    .pin_i    (pin_i),
    .fb_o     (fb_o)
  );

  // registered modes: feedback is the un-inverted register behind the pin
  assert_reg_fb_vs_pin_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[1] |-> (fb_o == (mode_i[0] ? pin_o : !pin_o)));
  assert_pin_fb_driven_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && pin_oe_o) |-> (fb_o == pin_o));
  assert_comb_follows_sum_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |-> (pin_o == (mode_i[0] ? sum_i : !sum_i)));
endmodule

// File: tb/olm_cell_tb.sv
`timescale 1ns/1ps
module olm_cell_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sum_i = 1'b0, oe_term_i = 1'b1, ar_i = 1'b0, ss_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       pl_en_i = 1'b0, pl_val_i = 1'b0, pin_i = 1'b0;
  logic       pin_o, pin_oe_o, fb_o;

  always #2.5 clk = ~clk;

  olm_cell u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sum_i(sum_i), .oe_term_i(oe_term_i),
    .ar_i(ar_i), .ss_i(ss_i), .mode_i(mode_i), .pl_en_i(pl_en_i),
    .pl_val_i(pl_val_i), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
    .fb_o(fb_o)
  );

  typedef struct {
    logic  pin;
    logic  oe;
    logic  fb;
    string req;
  } exp_t;

  exp_t  sb[$];
  event  sb_ev;
  int    checks = 0;
  int    errors = 0;
  logic  q_m = 1'b0;
  bit    done = 1'b0;

  // reference register, updated by the rules of R2/R3/R4/R11/R12
  task automatic tick();
    @(posedge clk);
    if (!rst_ni || ar_i) q_m = 1'b0;
    else if (pl_en_i)    q_m = pl_val_i;
    else if (ss_i)       q_m = 1'b1;
    else                 q_m = sum_i;
    #1;
  endtask

  task automatic expect_now(input string req);
    exp_t e;
    logic src;
    src   = mode_i[1] ? sum_i : q_m;
    e.pin = mode_i[0] ? src : ~src;
    e.oe  = oe_term_i;
    e.fb  = mode_i[1] ? (oe_term_i ? e.pin : pin_i) : q_m;
    e.req = req;
    sb.push_back(e);
    ->sb_ev;
    #0;
  endtask

  initial begin
    forever begin
      @(sb_ev);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (pin_o !== e.pin || pin_oe_o !== e.oe || fb_o !== e.fb) begin
          errors++;
          $display("FAIL %s: pin/oe/fb got %b%b%b expected %b%b%b", e.req,
                   pin_o, pin_oe_o, fb_o, e.pin, e.oe, e.fb);
        end
      end
    end
  end

  task automatic at_neg();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick(); tick();
    expect_now("R1");
    at_neg(); rst_ni = 1'b1;

    // R2 capture, active-high registered
    at_neg(); mode_i = 2'b01; sum_i = 1'b1; tick(); expect_now("R2");
    at_neg(); sum_i = 1'b0; tick(); expect_now("R2");
    at_neg(); sum_i = 1'b1; tick(); expect_now("R2");

    // R10 active-low register feedback stays true, pin_i ignored
    at_neg(); mode_i = 2'b00; pin_i = 1'b1; #1 expect_now("R10");
    at_neg(); pin_i = 1'b0; #1 expect_now("R10");

    // R3 async reset between edges
    at_neg(); ar_i = 1'b1; #1 q_m = 1'b0; expect_now("R3");
    at_neg(); ss_i = 1'b1; tick(); expect_now("R3");
    at_neg(); ar_i = 1'b0;

    // R4/R5 synchronous set with polarity
    sum_i = 1'b0; tick(); expect_now("R4");
    expect_now("R5");
    at_neg(); ss_i = 1'b0; mode_i = 2'b01; #1 expect_now("R5");

    // R11 preload, R12 preload over set
    at_neg(); ss_i = 1'b1; pl_en_i = 1'b1; pl_val_i = 1'b0; tick(); expect_now("R12");
    at_neg(); ss_i = 1'b0; pl_val_i = 1'b1; sum_i = 1'b0; tick(); expect_now("R11");
    at_neg(); pl_val_i = 1'b0; sum_i = 1'b1; tick(); expect_now("R11");
    // R12 async reset over preload and set
    at_neg(); pl_val_i = 1'b1; ss_i = 1'b1; ar_i = 1'b1; tick(); expect_now("R12");
    at_neg(); ar_i = 1'b0; pl_en_i = 1'b0; ss_i = 1'b0;

    // R8 output disabled, register still clocks
    at_neg(); oe_term_i = 1'b0; sum_i = 1'b1; tick(); expect_now("R8");
    at_neg(); oe_term_i = 1'b1; sum_i = 1'b0; #1 expect_now("R8");

    // R7/R6 combinational modes
    at_neg(); mode_i = 2'b11; sum_i = 1'b1; #1 expect_now("R7");
    at_neg(); mode_i = 2'b10; #1 expect_now("R6");
    at_neg(); sum_i = 1'b0; #1 expect_now("R7");

    // R9 pin feedback
    at_neg(); oe_term_i = 1'b0; pin_i = 1'b1; #1 expect_now("R9");
    at_neg(); pin_i = 1'b0; #1 expect_now("R9");
    at_neg(); oe_term_i = 1'b1; pin_i = 1'b1; #1 expect_now("R9");

    // R6 register clocks in combinational mode, revealed in registered mode
    at_neg(); mode_i = 2'b11; sum_i = 1'b1; tick();
    at_neg(); mode_i = 2'b01; sum_i = 1'b0; #1 expect_now("R6");
    at_neg(); mode_i = 2'b10; pl_en_i = 1'b1; pl_val_i = 1'b0; tick();
    at_neg(); pl_en_i = 1'b0; mode_i = 2'b00; sum_i = 1'b0; #1 expect_now("R6");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule